// File: doc/BRIEF.md
# Boot-Sector Decode and Autoselect Responder

This block sits beside the command logic of a 16-Mbit NOR flash array. It turns the incoming address into the index of one of eleven sectors of unequal size. A module parameter picks the layout: small boot sectors at the low end of the array (bottom boot) or at the high end (top boot). The block holds one protection bit per sector. It tells the program and erase engine whether a write to the addressed sector may proceed, and a temporary-unprotect flag overrides that decision.

When the command logic has put the device into autoselect mode, the block answers reads with the identification data. That data is the manufacturer code, the device code for the configured layout, or the protection status of the addressed sector. The answer depends on the low address offset and on the bus width, 16-bit word or 8-bit byte. The answer leaves a register one clock after the address is presented. The sector index and the write-allowed signal are combinational.

Top module: `bootsec_responder`

## Requirements
- R1: With the bottom layout, the word address selects sector 0 for 00000H–01FFFH, 1 for 02000H–02FFFH, 2 for 03000H–03FFFH and 3 for 04000H–1FFFFH. Each further 20000H-word region selects the next sector, from 4 up to 10 for E0000H–FFFFFH. `sector_o` is a combinational function of the address.
- R2: With the top layout, each 20000H-word region below E0000H selects sectors 0 to 6 in turn. Sector 7 is E0000H–FBFFFH, sector 8 is FC000H–FCFFFH, sector 9 is FD000H–FDFFFH and sector 10 is FE000H–FFFFFH.
- R3: In word mode (`byte_mode_i`=0) the word address is `addr_i[19:0]` and `addr_i[20]` has no effect. In byte mode the word address is `addr_i[20:1]`. In both modes the autoselect offset is `addr_i[7:0]`.
- R4: After a synchronous reset no sector is protected, so `write_ok_o` is 1 for every address, and `asel_data_o` is 0000H.
- R5: `prot_set_i` protects the sector addressed in the same cycle, and `prot_clr_i` unprotects it. The change is visible from the next cycle. If both requests are high, the sector becomes protected.
- R6: `write_ok_o` is 0 for a protected sector while `tmp_unprot_i` is 0, and 1 otherwise. Raising and then lowering `tmp_unprot_i` leaves the protection bits unchanged, so previously protected sectors are blocked again.
- R7: `asel_data_o` is registered and reflects the inputs of the previous cycle. It is 0000H whenever `asel_active_i` was 0.
- R8: Autoselect offset 00H returns the manufacturer code 0004H in both modes.
- R9: The device code is at offset 01H in word mode and 02H in byte mode. It is 2245H (word) or 0045H (byte) for the bottom layout, and 2227H (word) or 0027H (byte) for the top layout.
- R10: The protection status is at offset 02H in word mode and 04H in byte mode. It returns 0001H if the addressed sector's protection bit is set and 0000H if it is clear, whatever the state of `tmp_unprot_i`.
- R11: Every other autoselect offset returns 0000H. In byte mode the upper byte is always 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 21 | Address; byte address in byte mode, word address in bits 19:0 in word mode |
| byte_mode_i | input | 1 | 1 selects the 8-bit bus view |
| asel_active_i | input | 1 | Device is in autoselect mode |
| tmp_unprot_i | input | 1 | Temporary unprotect override active |
| prot_set_i | input | 1 | Protect the addressed sector |
| prot_clr_i | input | 1 | Unprotect the addressed sector |
| sector_o | output | 4 | Index of the addressed sector, 0 to 10 |
| write_ok_o | output | 1 | Program or erase allowed on the addressed sector |
| asel_data_o | output | 16 | Autoselect read data, one cycle after the address |

## Verification
Both layouts are instantiated side by side and driven with the same stimulus. Each sector boundary is presented as the last word of a sector and the first word of the next, which tells the two layouts' uneven boundaries apart. The same boundaries are repeated in byte mode, both with the extra low bit set and clear, and in word mode with bit 20 set, which separates the two address views. Protect, clear, simultaneous set-and-clear and a temporary-unprotect pulse are each followed by write-allowed and status reads on the target sector and on a neighbour. Autoselect reads walk through the defined offsets, the offsets next to them and offsets with nonzero upper bits, before a long pseudo-random phase.

// File: rtl/bootsec_pkg.sv
package bootsec_pkg;

    localparam int WADDR_W = 20;
    localparam int BADDR_W = WADDR_W + 1;
    localparam int NSECT   = 11;
    localparam int SECT_W  = $clog2(NSECT);
    localparam int SEL_LO  = 12;
    localparam int SEL_W   = WADDR_W - SEL_LO;
    localparam int RGN_W   = 3;
    localparam int FINE_W  = SEL_W - RGN_W;
    localparam int DATA_W  = 16;
    localparam int OFS_W   = 8;

    typedef enum logic {
        LAYOUT_BOTTOM = 1'b0,
        LAYOUT_TOP    = 1'b1
    } layout_e;

    typedef enum logic [1:0] {
        ASEL_MANUF,
        ASEL_DEVICE,
        ASEL_PROT,
        ASEL_NONE
    } asel_kind_e;

    typedef logic [SECT_W-1:0]  sect_t;
    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [DATA_W-1:0]  data_t;

    typedef struct packed {
        logic       active;
        logic       byte_mode;
        asel_kind_e kind;
    } asel_req_t;

    localparam logic [7:0] MANUF_CODE = 8'h04;
    localparam data_t      DEV_TOP    = 16'h2227;
    localparam data_t      DEV_BOT    = 16'h2245;

    // Word address seen by the sector decoder for either bus view.
    function automatic waddr_t word_addr(input logic [BADDR_W-1:0] a, input logic byte_mode);
        return byte_mode ? a[BADDR_W-1:1] : a[WADDR_W-1:0];
    endfunction

    // Byte offsets are the word offsets shifted left by one.
    function automatic asel_kind_e asel_kind(input logic [OFS_W-1:0] ofs, input logic byte_mode);
        logic [OFS_W-1:0] idx;
        if (byte_mode && ofs[0]) return ASEL_NONE;
        idx = byte_mode ? (ofs >> 1) : ofs;
        case (idx)
            8'd0:    return ASEL_MANUF;
            8'd1:    return ASEL_DEVICE;
            8'd2:    return ASEL_PROT;
            default: return ASEL_NONE;
        endcase
    endfunction

    function automatic data_t device_code(input layout_e layout, input logic byte_mode);
        data_t code;
        code = (layout == LAYOUT_TOP) ? DEV_TOP : DEV_BOT;
        return byte_mode ? {8'h00, code[7:0]} : code;
    endfunction

endpackage

// File: rtl/bootsec_sector_map.sv
module bootsec_sector_map
    import bootsec_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_BOTTOM
) (
    input  waddr_t waddr_i,
    output sect_t  sect_o
);

    logic [SEL_W-1:0]  sel;
    logic [RGN_W-1:0]  region;
    logic [FINE_W-1:0] fine;

    assign sel    = waddr_i[WADDR_W-1:SEL_LO];
    assign region = sel[SEL_W-1:FINE_W];
    assign fine   = sel[FINE_W-1:0];

    generate
        if (LAYOUT == LAYOUT_BOTTOM) begin : g_bottom
            // Small sectors live in region 0; big regions follow from 4.
            always_comb begin
                if (region != '0)           sect_o = sect_t'(region) + sect_t'(3);
                else if (fine <= 5'd1)      sect_o = sect_t'(0);
                else if (fine == 5'd2)      sect_o = sect_t'(1);
                else if (fine == 5'd3)      sect_o = sect_t'(2);
                else                        sect_o = sect_t'(3);
            end
        end else begin : g_top
            // Small sectors live at the end of the last region.
            always_comb begin
                if (region != '1)           sect_o = sect_t'(region);
                else if (fine <= 5'd27)     sect_o = sect_t'(7);
                else if (fine == 5'd28)     sect_o = sect_t'(8);
                else if (fine == 5'd29)     sect_o = sect_t'(9);
                else                        sect_o = sect_t'(10);
            end
        end
    endgenerate

endmodule

// File: rtl/bootsec_prot_bank.sv
module bootsec_prot_bank
    import bootsec_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  sect_t sect_i,
    input  logic  set_i,
    input  logic  clr_i,
    input  logic  tmp_unprot_i,
    output logic  prot_hit_o,
    output logic  write_ok_o
);

    localparam int NPAD = 1 << SECT_W;

    logic [NSECT-1:0] prot_q;
    logic [NSECT-1:0] prot_d;
    logic [NPAD-1:0]  prot_pad;

    always_comb begin
        prot_d = prot_q;
        for (int s = 0; s < NSECT; s++) begin
            if (sect_i == sect_t'(s)) begin
                if (set_i)      prot_d[s] = 1'b1;
                else if (clr_i) prot_d[s] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) prot_q <= '0;
        else       prot_q <= prot_d;
    end

    assign prot_pad   = NPAD'(prot_q);
    assign prot_hit_o = prot_pad[sect_i];
    assign write_ok_o = tmp_unprot_i | ~prot_hit_o;

    // R4: nothing protected right after reset
    a_r4_reset_unprotected: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (prot_q == '0));

    // R5/R6: a set on a held sector blocks writes next cycle without override
    a_r5_set_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(set_i && !rst_i) && $stable(sect_i) && !tmp_unprot_i) |-> !write_ok_o);

    // R5: a lone clear frees the held sector next cycle
    a_r5_clear_frees: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(clr_i && !set_i && !rst_i) && $stable(sect_i)) |-> write_ok_o);

    // R6: override always allows the write
    a_r6_tmp_override: assert property (@(posedge clk_i) disable iff (rst_i)
        tmp_unprot_i |-> write_ok_o);

endmodule

// File: rtl/bootsec_asel_read.sv
module bootsec_asel_read
    import bootsec_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_BOTTOM
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             active_i,
    input  logic             byte_mode_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             sect_prot_i,
    output data_t            data_o
);

    asel_req_t req;
    data_t     data_d;
    data_t     data_q;

    always_comb begin
        req.active    = active_i;
        req.byte_mode = byte_mode_i;
        req.kind      = asel_kind(ofs_i, byte_mode_i);
    end

    always_comb begin
        data_d = '0;
        if (req.active) begin
            case (req.kind)
                ASEL_MANUF:  data_d = {8'h00, MANUF_CODE};
                ASEL_DEVICE: data_d = device_code(LAYOUT, req.byte_mode);
                ASEL_PROT:   data_d = {{(DATA_W-1){1'b0}}, sect_prot_i};
                default:     data_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) data_q <= '0;
        else       data_q <= data_d;
    end

    assign data_o = data_q;

    // R7: idle autoselect gives zero one cycle later
    a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        !active_i |=> (data_o == '0));

    // R8: manufacturer code at offset zero
    a_r8_manuf_code: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_i && ofs_i == '0) |=> (data_o == 16'h0004));

    // R10: status of a protected sector reads as one
    a_r10_status_set: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_i && sect_prot_i && ofs_i == (byte_mode_i ? 8'h04 : 8'h02)) |=> (data_o == 16'h0001));

    // R11: byte view never drives the upper byte
    a_r11_byte_upper: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_mode_i |=> (data_o[DATA_W-1:8] == '0));

endmodule

// File: rtl/bootsec_responder.sv
module bootsec_responder
    import bootsec_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_BOTTOM
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [BADDR_W-1:0] addr_i,
    input  logic               byte_mode_i,
    input  logic               asel_active_i,
    input  logic               tmp_unprot_i,
    input  logic               prot_set_i,
    input  logic               prot_clr_i,
    output logic [SECT_W-1:0]  sector_o,
    output logic               write_ok_o,
    output logic [DATA_W-1:0]  asel_data_o
);

    waddr_t waddr;
    sect_t  sect;
    logic   prot_hit;

    assign waddr = word_addr(addr_i, byte_mode_i);

    bootsec_sector_map #(.LAYOUT(LAYOUT)) u_map (
        .waddr_i (waddr),
        .sect_o  (sect)
    );

    bootsec_prot_bank u_prot (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .sect_i       (sect),
        .set_i        (prot_set_i),
        .clr_i        (prot_clr_i),
        .tmp_unprot_i (tmp_unprot_i),
        .prot_hit_o   (prot_hit),
        .write_ok_o   (write_ok_o)
    );

    bootsec_asel_read #(.LAYOUT(LAYOUT)) u_asel (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .active_i    (asel_active_i),
        .byte_mode_i (byte_mode_i),
        .ofs_i       (addr_i[OFS_W-1:0]),
        .sect_prot_i (prot_hit),
        .data_o      (asel_data_o)
    );

    assign sector_o = sect;

    // R1/R2: decoded index always names a real sector
    a_r1_sector_range: assert property (@(posedge clk_i) disable iff (rst_i)
        sector_o < SECT_W'(NSECT));

endmodule

// File: tb/bootsec_responder_bench.sv
module bootsec_responder_bench;
    import bootsec_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] addr = '0;
    logic        bm = 1'b0, act = 1'b0, tmp = 1'b0, pset = 1'b0, pclr = 1'b0;

    logic [3:0]  sec_b, sec_t;
    logic        wok_b, wok_t;
    logic [15:0] dat_b, dat_t;

    int n_chk = 0;
    int n_err = 0;

    bit [10:0]   m_prot_b = '0;
    bit [10:0]   m_prot_t = '0;
    logic [15:0] exp_b = '0, exp_t = '0;
    string       rd_tag = "R4";

    always #4 clk = ~clk;

    bootsec_responder #(.LAYOUT(LAYOUT_BOTTOM)) u_bootsec_responder (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .byte_mode_i(bm),
        .asel_active_i(act), .tmp_unprot_i(tmp), .prot_set_i(pset), .prot_clr_i(pclr),
        .sector_o(sec_b), .write_ok_o(wok_b), .asel_data_o(dat_b));

    bootsec_responder #(.LAYOUT(LAYOUT_TOP)) u_bootsec_responder_top (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .byte_mode_i(bm),
        .asel_active_i(act), .tmp_unprot_i(tmp), .prot_set_i(pset), .prot_clr_i(pclr),
        .sector_o(sec_t), .write_ok_o(wok_t), .asel_data_o(dat_t));

    function automatic int ref_word(input int a, input bit b);
        return b ? (a / 2) : (a % 32'h100000);
    endfunction

    function automatic int ref_sector(input int w, input bit top);
        if (!top) begin
            if (w < 32'h02000) return 0;
            if (w < 32'h03000) return 1;
            if (w < 32'h04000) return 2;
            if (w < 32'h20000) return 3;
            return w / 32'h20000 + 3;
        end
        if (w < 32'hE0000) return w / 32'h20000;
        if (w < 32'hFC000) return 7;
        if (w < 32'hFD000) return 8;
        if (w < 32'hFE000) return 9;
        return 10;
    endfunction

    function automatic int ref_asel(input int a, input bit b, input bit ac, input bit top, input bit pbit);
        int ofs;
        ofs = a % 256;
        if (!ac) return 0;
        if (ofs == 0) return 4;
        if (b) begin
            if (ofs == 2) return top ? 32'h27 : 32'h45;
            if (ofs == 4) return pbit ? 1 : 0;
        end else begin
            if (ofs == 1) return top ? 32'h2227 : 32'h2245;
            if (ofs == 2) return pbit ? 1 : 0;
        end
        return 0;
    endfunction

    function automatic string asel_tag(input int a, input bit b, input bit ac);
        int ofs;
        ofs = a % 256;
        if (!ac) return "R7";
        if (ofs == 0) return "R8";
        if ((b && ofs == 2) || (!b && ofs == 1)) return "R9";
        if ((b && ofs == 4) || (!b && ofs == 2)) return "R10";
        return "R11";
    endfunction

    task automatic chk(input bit ok, input string tag, input int actv, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actv, expv, $time);
        end
    endtask

    task automatic cyc(input int a, input bit b, input bit ac, input bit tm, input bit st, input bit cl);
        int w, sb, stp, eb, et;
        @(negedge clk);
        chk(dat_b == exp_b[15:0], {rd_tag, " bottom asel"}, int'(dat_b), int'(exp_b));
        chk(dat_t == exp_t[15:0], {rd_tag, " top asel"}, int'(dat_t), int'(exp_t));
        addr = a[20:0]; bm = b; act = ac; tmp = tm; pset = st; pclr = cl;
        #1;
        w   = ref_word(a, b);
        sb  = ref_sector(w, 1'b0);
        stp = ref_sector(w, 1'b1);
        chk(int'(sec_b) == sb, b ? "R3 R1 bottom sector" : "R1 bottom sector", int'(sec_b), sb);
        chk(int'(sec_t) == stp, b ? "R3 R2 top sector" : "R2 top sector", int'(sec_t), stp);
        chk(wok_b == (tm | !m_prot_b[sb]), "R6 bottom write_ok", int'(wok_b), int'(tm | !m_prot_b[sb]));
        chk(wok_t == (tm | !m_prot_t[stp]), "R6 top write_ok", int'(wok_t), int'(tm | !m_prot_t[stp]));
        eb = ref_asel(a, b, ac, 1'b0, m_prot_b[sb]);
        et = ref_asel(a, b, ac, 1'b1, m_prot_t[stp]);
        exp_b = eb[15:0];
        exp_t = et[15:0];
        rd_tag = asel_tag(a, b, ac);
        if (st) begin
            m_prot_b[sb] = 1'b1; m_prot_t[stp] = 1'b1;
        end else if (cl) begin
            m_prot_b[sb] = 1'b0; m_prot_t[stp] = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int bnd[20];
        bnd = '{32'h00000, 32'h01FFF, 32'h02000, 32'h02FFF, 32'h03000, 32'h03FFF,
                32'h04000, 32'h1FFFF, 32'h20000, 32'h3FFFF, 32'h40000, 32'hC0000,
                32'hDFFFF, 32'hE0000, 32'hFBFFF, 32'hFC000, 32'hFCFFF, 32'hFD000,
                32'hFDFFF, 32'hFFFFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4: reset state, every sector writable
        for (int i = 0; i < 20; i++) cyc(bnd[i], 0, 0, 0, 0, 0);

        // R1 R2: word-mode boundaries, R3: bit 20 ignored
        for (int i = 0; i < 20; i++) cyc(bnd[i], 0, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(bnd[i] + 32'h100000, 0, 0, 0, 0, 0);
        // R3: byte-mode view, low bit clear and set
        for (int i = 0; i < 20; i++) cyc(bnd[i] * 2, 1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(bnd[i] * 2 + 1, 1, 0, 0, 0, 0);

        // R5: protect word 02000H (bottom 1, top 0)
        cyc(32'h02000, 0, 0, 0, 1, 0);
        cyc(32'h02000, 0, 0, 0, 0, 0);
        cyc(32'h03000, 0, 0, 0, 0, 0);
        // R6: override then restore
        cyc(32'h02000, 0, 0, 1, 0, 0);
        cyc(32'h02000, 0, 0, 0, 0, 0);
        // R10: status reads in both views, protected and neighbour
        cyc(32'h02002, 0, 1, 0, 0, 0);
        cyc(32'h04004, 1, 1, 0, 0, 0);
        cyc(32'h03002, 0, 1, 0, 0, 0);
        cyc(32'h02002, 0, 1, 1, 0, 0);
        // R5: set and clear together keeps protection, clear alone frees
        cyc(32'hFE000, 0, 0, 0, 1, 1);
        cyc(32'hFE002, 0, 1, 0, 0, 0);
        cyc(32'h02000, 0, 0, 0, 0, 1);
        cyc(32'h02002, 0, 1, 0, 0, 0);

        // R8 R9 R10 R11: offset walk in both views, upper bits nonzero
        for (int o = 0; o < 8; o++) begin
            cyc(32'hFE000 + o, 0, 1, 0, 0, 0);
            cyc(32'h1FC100 + o, 1, 1, 0, 0, 0);
            cyc(32'h12300 + o, 0, 1, 0, 0, 0);
        end
        cyc(32'h000FF, 0, 1, 0, 0, 0);
        cyc(32'h00002, 0, 0, 0, 0, 0);

        // pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            int r, a;
            r = int'($urandom % 16);
            a = int'($urandom % 32'h200000);
            if (r < 6) a = (a & 32'h1FFF00) | int'($urandom % 6);
            cyc(a, r[0], r < 10, ($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0);
        end
        cyc(0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule